// File: doc/BRIEF.md
# Prioritised Interrupt Context Sequencer

This block sits beside a simple accumulator processor and decides, at each instruction boundary, whether to divert the processor into an interrupt service routine. The processor pulses an end-of-instruction strobe when it has finished a fetch-decode-execute cycle. Only in that cycle does the block look at the pending requests. Four request lines are ranked by index, with line 0 the most urgent. A request is taken only if it outranks the routine that is already running. Taking it masks every line at the same rank or below.

On entry the block holds the processor with a stall output. It writes the program counter, accumulator, index register, flags and the previous priority level into a stack memory, one word per cycle, with the stack pointer moving downwards. It then loads the program counter with the fixed routine address of the accepted line. When the routine ends, the processor raises a return request together with the strobe. The block then stalls again and reads the five words back in the opposite order. It hands the flags, index and accumulator back through a register-write port, restores the old priority level and reloads the interrupted program counter. Routines can nest, so a more urgent line may interrupt a less urgent routine.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset, stall, irq_ack, pc_load, reg_wr, mem_we and mem_re are all 0, and no routine is active (priority level value 4).
- R2: Requests and return requests have an effect only in a cycle where instr_done is 1. Pending requests without the strobe never cause a stall or an acknowledge.
- R3: Among the accepted candidates, the lowest-numbered pending line wins. irq_ack is one-hot for that line for exactly one cycle, the cycle after the accepting strobe.
- R4: While a routine of level L is active, a request on any line numbered L or higher is not accepted.
- R5: On acceptance the block writes five words on consecutive cycles, in this order: PC (zero-extended), ACC, IX, FLAGS, old level (4 meaning none). The addresses are the current stack pointer minus 1, minus 2, and so on. The stack pointer starts at SP_INIT. stall is 1 for exactly those 5 cycles.
- R6: In the cycle after the last push, stall is 0 and pc_load pulses for one cycle, with pc_value equal to the fixed vector of the accepted line.
- R7: A return request at a boundary while a routine is active reads the five words back in reverse order, from ascending addresses. Each read has one cycle of memory latency, so stall is 1 for 10 cycles. reg_wr delivers FLAGS (reg_sel 2), then IX (reg_sel 1), then ACC (reg_sel 0). pc_load then delivers the saved PC in the cycle after stall falls, and the saved level becomes current again.
- R8: A return request while no routine is active is ignored: no stall, no memory read, no restore. A request in the same strobe is judged as usual.
- R9: If a return request and an outranking request arrive at the same boundary, the return is carried out and the request is not acknowledged. The request is judged again at a later boundary against the restored level.
- R10: Nested entries stack frames below one another. After each return, the stack pointer is back where it was before the matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Pending request lines, bit 0 most urgent |
| instr_done | input | 1 | End-of-instruction strobe from the processor |
| ret_req | input | 1 | Routine-complete request, valid with instr_done |
| pc_in | input | ADDR_W | Current program counter to save |
| acc_in | input | DATA_W | Accumulator to save |
| ix_in | input | DATA_W | Index register to save |
| flags_in | input | DATA_W | Status flags to save |
| stall | output | 1 | Holds the processor during push or pop |
| irq_ack | output | NUM_SRC | One-cycle one-hot acknowledge of the accepted line |
| pc_load | output | 1 | Load pc_value into the program counter |
| pc_value | output | ADDR_W | Vector or restored program counter |
| reg_wr | output | 1 | Restore strobe for ACC, IX or FLAGS |
| reg_sel | output | 2 | Restore target: 0 ACC, 1 IX, 2 FLAGS |
| reg_data | output | DATA_W | Restored register value |
| mem_we | output | 1 | Stack write enable |
| mem_re | output | 1 | Stack read enable (data expected next cycle) |
| mem_addr | output | SP_W | Stack address |
| mem_wdata | output | DATA_W | Stack write data |
| mem_rdata | input | DATA_W | Stack read data, one cycle after mem_re |

## Verification
A return request and a new interrupt request can fall on the same instruction boundary. The bench provokes this in two ways. First, it raises the return together with a line that outranks the routine being left; it then expects the full ten-cycle pop, no acknowledge, and acceptance only at the following boundary. Second, it raises a return while nothing is active, alongside an ordinary request; the return must vanish without any memory read, while the request is accepted and pushed as normal.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP_RD,
        ST_POP_WB
    } seq_state_e;

    localparam int CTX_WORDS  = 5;
    localparam int IDX_W      = 3;
    // Push order; pop visits these in reverse
    localparam int SLOT_PC    = 0;
    localparam int SLOT_ACC   = 1;
    localparam int SLOT_IX    = 2;
    localparam int SLOT_FLAGS = 3;
    localparam int SLOT_LVL   = 4;

    localparam logic [1:0] SEL_ACC   = 2'd0;
    localparam logic [1:0] SEL_IX    = 2'd1;
    localparam logic [1:0] SEL_FLAGS = 2'd2;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 4,
    parameter int LVL_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [LVL_W-1:0]   cur_lvl,
    output logic               hit,
    output logic [LVL_W-1:0]   win
);
    logic [NUM_SRC-1:0] elig;

    // A line is eligible only if it outranks the running level
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = req[i] && (LVL_W'(i) < cur_lvl);
    end

    always_comb begin
        win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) win = LVL_W'(i);
        end
    end

    assign hit = |elig;
endmodule

// File: rtl/irq_ctx_mux.sv
module irq_ctx_mux
    import irq_ctx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int LVL_W  = 3
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] pc_s,
    input  logic [DATA_W-1:0] acc_s,
    input  logic [DATA_W-1:0] ix_s,
    input  logic [DATA_W-1:0] fl_s,
    input  logic [LVL_W-1:0]  lvl_s,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] slots [CTX_WORDS];

    assign slots[SLOT_PC]    = DATA_W'(pc_s);
    assign slots[SLOT_ACC]   = acc_s;
    assign slots[SLOT_IX]    = ix_s;
    assign slots[SLOT_FLAGS] = fl_s;
    assign slots[SLOT_LVL]   = DATA_W'(lvl_s);

    always_comb begin
        word = '0;
        for (int i = 0; i < CTX_WORDS; i++) begin
            if (idx == IDX_W'(i)) word = slots[i];
        end
    end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int                          NUM_SRC = 4,
    parameter int                          ADDR_W  = 12,
    parameter int                          DATA_W  = 16,
    parameter int                          SP_W    = 8,
    parameter logic [SP_W-1:0]             SP_INIT = 8'h80,
    parameter logic [NUM_SRC*ADDR_W-1:0]   VECTORS = {12'h300, 12'h200, 12'h180, 12'h100}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               instr_done,
    input  logic               ret_req,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [DATA_W-1:0]  acc_in,
    input  logic [DATA_W-1:0]  ix_in,
    input  logic [DATA_W-1:0]  flags_in,
    output logic               stall,
    output logic [NUM_SRC-1:0] irq_ack,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  pc_value,
    output logic               reg_wr,
    output logic [1:0]         reg_sel,
    output logic [DATA_W-1:0]  reg_data,
    output logic               mem_we,
    output logic               mem_re,
    output logic [SP_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);
    localparam int              LVL_W    = $clog2(NUM_SRC + 1);
    localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(NUM_SRC);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CTX_WORDS - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [SP_W-1:0]    sp;
        logic [LVL_W-1:0]   lvl;
        logic [LVL_W-1:0]   win;
        logic [ADDR_W-1:0]  pc_s;
        logic [DATA_W-1:0]  acc_s;
        logic [DATA_W-1:0]  ix_s;
        logic [DATA_W-1:0]  fl_s;
        logic [LVL_W-1:0]   lvl_s;
        logic [NUM_SRC-1:0] ack;
        logic               pcl;
        logic [ADDR_W-1:0]  pcv;
        logic               rw;
        logic [1:0]         rsel;
        logic [DATA_W-1:0]  rdat;
    } seq_t;

    seq_t s_d, s_q;

    logic             pick_hit;
    logic [LVL_W-1:0] pick_win;
    logic [DATA_W-1:0] push_word;
    logic             active;

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
        .req     (irq_req),
        .cur_lvl (s_q.lvl),
        .hit     (pick_hit),
        .win     (pick_win)
    );

    irq_ctx_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_mux (
        .idx   (s_q.idx),
        .pc_s  (s_q.pc_s),
        .acc_s (s_q.acc_s),
        .ix_s  (s_q.ix_s),
        .fl_s  (s_q.fl_s),
        .lvl_s (s_q.lvl_s),
        .word  (push_word)
    );

    assign active = (s_q.lvl != LVL_NONE);

    always_comb begin
        s_d      = s_q;
        s_d.ack  = '0;
        s_d.pcl  = 1'b0;
        s_d.rw   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (instr_done) begin
                    if (ret_req && active) begin
                        // return outranks any request at the same boundary
                        s_d.st  = ST_POP_RD;
                        s_d.idx = '0;
                    end else if (pick_hit) begin
                        s_d.st    = ST_PUSH;
                        s_d.idx   = '0;
                        s_d.pc_s  = pc_in;
                        s_d.acc_s = acc_in;
                        s_d.ix_s  = ix_in;
                        s_d.fl_s  = flags_in;
                        s_d.lvl_s = s_q.lvl;
                        s_d.lvl   = pick_win;
                        s_d.win   = pick_win;
                        s_d.ack   = NUM_SRC'(1) << pick_win;
                    end
                end
            end
            ST_PUSH: begin
                s_d.sp = s_q.sp - 1'b1;
                if (s_q.idx == IDX_LAST) begin
                    s_d.st  = ST_IDLE;
                    s_d.pcl = 1'b1;
                    s_d.pcv = VECTORS[s_q.win*ADDR_W +: ADDR_W];
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            ST_POP_RD: begin
                s_d.st = ST_POP_WB;
            end
            ST_POP_WB: begin
                s_d.sp = s_q.sp + 1'b1;
                unique case (s_q.idx)
                    3'd0: s_d.lvl = mem_rdata[LVL_W-1:0];
                    3'd1: begin s_d.rw = 1'b1; s_d.rsel = SEL_FLAGS; s_d.rdat = mem_rdata; end
                    3'd2: begin s_d.rw = 1'b1; s_d.rsel = SEL_IX;    s_d.rdat = mem_rdata; end
                    3'd3: begin s_d.rw = 1'b1; s_d.rsel = SEL_ACC;   s_d.rdat = mem_rdata; end
                    default: begin s_d.pcl = 1'b1; s_d.pcv = mem_rdata[ADDR_W-1:0]; end
                endcase
                if (s_q.idx == IDX_LAST) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.st  = ST_POP_RD;
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.sp  <= SP_INIT;
            s_q.lvl <= LVL_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign stall     = (s_q.st != ST_IDLE);
    assign irq_ack   = s_q.ack;
    assign pc_load   = s_q.pcl;
    assign pc_value  = s_q.pcv;
    assign reg_wr    = s_q.rw;
    assign reg_sel   = s_q.rsel;
    assign reg_data  = s_q.rdat;
    assign mem_we    = (s_q.st == ST_PUSH);
    assign mem_re    = (s_q.st == ST_POP_RD);
    assign mem_addr  = (s_q.st == ST_PUSH) ? (s_q.sp - 1'b1) : s_q.sp;
    assign mem_wdata = push_word;
endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk #(
    parameter int NUM_SRC = 4,
    parameter int SP_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_done,
    input logic               stall,
    input logic [NUM_SRC-1:0] irq_ack,
    input logic               pc_load,
    input logic               mem_we,
    input logic               mem_re,
    input logic [SP_W-1:0]    mem_addr
);
    p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));

    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |=> !(|irq_ack));

    p_ack_with_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |-> (stall && mem_we));

    p_push_descends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));

    p_no_mem_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> (!mem_we && !mem_re));

    p_we_re_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_pcload_after_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (!stall && $past(stall)));

    p_stall_from_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(instr_done));
endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(.NUM_SRC(NUM_SRC), .SP_W(SP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .stall      (stall),
    .irq_ack    (irq_ack),
    .pc_load    (pc_load),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr)
);

// File: tb/sim_irq_ctx_seq.sv
module sim_irq_ctx_seq;
    localparam int         CLK_PERIOD = 10;
    localparam int         NSRC       = 4;
    localparam logic [7:0] SP0        = 8'h80;
    localparam logic [47:0] VEC_ALL   = {12'h300, 12'h200, 12'h180, 12'h100};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_req = '0;
    logic        instr_done = 1'b0;
    logic        ret_req = 1'b0;
    logic [11:0] pc_in = '0;
    logic [15:0] acc_in = '0, ix_in = '0, flags_in = '0;
    logic        stall, pc_load, reg_wr, mem_we, mem_re;
    logic [3:0]  irq_ack;
    logic [11:0] pc_value;
    logic [1:0]  reg_sel;
    logic [15:0] reg_data, mem_wdata, mem_rdata;
    logic [7:0]  mem_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctx_seq #(.NUM_SRC(NSRC), .SP_INIT(SP0), .VECTORS(VEC_ALL)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
        .ret_req(ret_req), .pc_in(pc_in), .acc_in(acc_in), .ix_in(ix_in),
        .flags_in(flags_in), .stall(stall), .irq_ack(irq_ack), .pc_load(pc_load),
        .pc_value(pc_value), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_data(reg_data),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [15:0] ram [256];
    always_ff @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    // scoreboard item: kind 0 ack, 1 stack write, 2 register restore, 3 pc load
    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] a;
        logic [15:0] d;
        logic [7:0]  req;
    } ev_t;
    ev_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    int stall_cnt = 0, re_cnt = 0;
    bit running = 1'b1;

    int          m_lvl = 4;
    logic [7:0]  m_sp = SP0;
    logic [15:0] m_stack [256];

    function automatic logic [11:0] vec_of(int s);
        case (s)
            0: return 12'h100;
            1: return 12'h180;
            2: return 12'h200;
            default: return 12'h300;
        endcase
    endfunction

    function automatic void push_exp(logic [1:0] k, logic [15:0] a, logic [15:0] d, int r);
        ev_t e;
        e.kind = k; e.a = a; e.d = d; e.req = 8'(r);
        exp_q.push_back(e);
    endfunction

    task automatic check(bit ok, int r, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", r, what, act, expv);
        end
    endtask

    task automatic observe(logic [1:0] k, logic [15:0] a, logic [15:0] d);
        ev_t e;
        n_chk++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R8/R9 unexpected event: actual kind %0d a=%h d=%h expected none", k, a, d);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.a != a || e.d != d) begin
                n_fail++;
                $display("FAIL R%0d event: actual kind %0d a=%h d=%h expected kind %0d a=%h d=%h",
                         e.req, k, a, d, e.kind, e.a, e.d);
            end
        end
    endtask

    // monitor: compares each produced item against the queue front
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (|irq_ack) observe(2'd0, {12'h0, irq_ack}, 16'h0);
            if (mem_we)   observe(2'd1, {8'h0, mem_addr}, mem_wdata);
            if (reg_wr)   observe(2'd2, {14'h0, reg_sel}, reg_data);
            if (pc_load)  observe(2'd3, 16'h0, {4'h0, pc_value});
            if (stall)    stall_cnt++;
            if (mem_re)   re_cnt++;
        end
    end

    // driver: one instruction boundary, with the expected outcome queued first
    task automatic boundary(logic [3:0] req, bit ret, logic [11:0] pc, logic [15:0] acc,
                            logic [15:0] ix, logic [15:0] fl, int r);
        bit ret_taken;
        int win, exp_stall, exp_re;
        logic [15:0] w [5];
        ret_taken = ret && (m_lvl != 4);
        exp_stall = 0;
        exp_re = 0;
        if (ret_taken) begin
            // R7: pop level, flags, ix, acc, pc
            for (int i = 0; i < 5; i++) begin
                w[i] = m_stack[m_sp];
                m_sp = m_sp + 8'd1;
            end
            push_exp(2'd2, 16'd2, w[1], 7);
            push_exp(2'd2, 16'd1, w[2], 7);
            push_exp(2'd2, 16'd0, w[3], 7);
            push_exp(2'd3, 16'h0, w[4], 7);
            m_lvl = int'(w[0]);
            exp_stall = 10;
            exp_re = 5;
        end else begin
            win = -1;
            for (int i = 0; i < 4; i++) if (req[i] && win < 0) win = i;
            if (win >= 0 && win < m_lvl) begin
                // R3 ack, R5 pushes, R6 vector
                push_exp(2'd0, 16'(1 << win), 16'h0, 3);
                w[0] = {4'h0, pc}; w[1] = acc; w[2] = ix; w[3] = fl; w[4] = 16'(m_lvl);
                for (int i = 0; i < 5; i++) begin
                    m_sp = m_sp - 8'd1;
                    m_stack[m_sp] = w[i];
                    push_exp(2'd1, {8'h0, m_sp}, w[i], 5);
                end
                push_exp(2'd3, 16'h0, {4'h0, vec_of(win)}, 6);
                m_lvl = win;
                exp_stall = 5;
            end
        end
        @(negedge clk);
        stall_cnt = 0;
        re_cnt = 0;
        irq_req = req; ret_req = ret; instr_done = 1'b1;
        pc_in = pc; acc_in = acc; ix_in = ix; flags_in = fl;
        @(negedge clk);
        instr_done = 1'b0; ret_req = 1'b0; irq_req = '0;
        repeat (14) @(negedge clk);
        check(stall_cnt == exp_stall, r, "stall cycles", stall_cnt, exp_stall);
        check(re_cnt == exp_re, r, "stack reads", re_cnt, exp_re);
        check(exp_q.size() == 0, r, "items left in queue", exp_q.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(stall == 1'b0, 1, "stall after reset", stall, 0);
        check(irq_ack == 4'h0, 1, "ack after reset", irq_ack, 0);
        check(pc_load == 1'b0, 1, "pc_load after reset", pc_load, 0);
        check(!mem_we && !mem_re && !reg_wr, 1, "bus idle after reset", mem_we | mem_re, 0);

        // R2: pending line without strobe does nothing
        stall_cnt = 0;
        irq_req = 4'b0001;
        repeat (8) @(negedge clk);
        irq_req = '0;
        check(stall_cnt == 0, 2, "stall without strobe", stall_cnt, 0);
        check(exp_q.size() == 0, 2, "queue without strobe", exp_q.size(), 0);

        // R8: return with nothing active
        boundary(4'b0000, 1'b1, 12'h000, 16'h0, 16'h0, 16'h0, 8);
        // R3: lines 1 and 3 pending, line 1 wins
        boundary(4'b1010, 1'b0, 12'h045, 16'hA1A1, 16'h0B0B, 16'h0003, 3);
        // R4: lines 1 and 2 while level 1 runs, both masked
        boundary(4'b0110, 1'b0, 12'h187, 16'h1111, 16'h2222, 16'h0001, 4);
        // R10: nested entry by line 0
        boundary(4'b0001, 1'b0, 12'h190, 16'hC3C3, 16'h0044, 16'h0002, 10);
        // R7: return to level 1 routine
        boundary(4'b0000, 1'b1, 12'h105, 16'h0, 16'h0, 16'h0, 7);
        // R9: return and an outranking request together, return wins
        boundary(4'b0001, 1'b1, 12'h19A, 16'h0, 16'h0, 16'h0, 9);
        // R9: same request judged again at the next boundary
        boundary(4'b0001, 1'b0, 12'h046, 16'h5A5A, 16'h7E00, 16'h0008, 9);
        // R7: plain return
        boundary(4'b0000, 1'b1, 12'h10F, 16'h0, 16'h0, 16'h0, 7);
        // R8: return ignored while a request is accepted in the same strobe
        boundary(4'b0100, 1'b1, 12'h050, 16'hFFFF, 16'h8001, 16'h00F0, 8);
        // R10: after unwinding, the frame lands at the start of the stack
        boundary(4'b0000, 1'b1, 12'h205, 16'h0, 16'h0, 16'h0, 10);
        check(m_sp == SP0, 10, "model stack balanced", int'(m_sp), int'(SP0));
        boundary(4'b1000, 1'b0, 12'h060, 16'h1234, 16'h5678, 16'h9ABC, 10);
        boundary(4'b0000, 1'b1, 12'h305, 16'h0, 16'h0, 16'h0, 7);

        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule